// File: doc/BRIEF.md
# BCD 24-Hour Clock with Hourly Chime

This block keeps the time of day as three chained BCD counters: seconds and minutes that each count 00 to 59, and hours that count 00 to 23. Each rising edge of the counting clock is one second. When the seconds counter wraps, the minutes counter advances. When the minutes counter wraps, the hours counter advances. Two active-low buttons let an operator advance the minutes or the hours by hand. Holding a button forces that stage to step once on every counting-clock edge.

While the minutes read 00, the block drives a buzzer output. During that minute it also walks three indicator lamps through a short repeating pattern. The time is shown on a six-digit multiplexed seven-segment display. A separate scan clock steps a digit selector through the six positions, and the segment outputs carry the glyph for the selected digit.

Top module: `bcd_chime_clock`

## Requirements
- R1: Seconds are two BCD digits (units 0-9, tens 0-5). They advance by one on every counting-clock edge and go from 59 to 00.
- R2: Minutes are two BCD digits (units 0-9, tens 0-5). They advance only on an edge where the seconds go from 59 to 00, or when forced by set-minute. A step of the minutes from 59 to 00 advances the hours.
- R3: Hours are a 2-bit tens digit and a 4-bit units digit. They count 00 to 23 and then go to 00.
- R4: set_min_n is active low and passes through a two-flop synchroniser. Each counting-clock edge that samples it low causes exactly one minute advance, two edges later. An edge where a forced advance and a seconds wrap coincide advances the minutes by one only.
- R5: set_hour_n works the same way on the hours. It leaves the minutes and seconds to their normal counting.
- R6: rst_n is active low and asynchronous. It sets the time to 00:00:00 and the digit selector to 0, on both clocks.
- R7: buzzer is 1 exactly while the minutes read 00. It is 0 otherwise.
- R8: While the minutes read 00, lamp steps through 000, 001, 010, 100 and repeats, one step per counting-clock edge. It shows 000 in the first cycle that the minutes read 00. At any other minute, lamp is 000.
- R9: digit_sel counts 0,1,2,3,4,5 and then returns to 0, one step per rising edge of scan_clk. The positions show, in order: hour tens, hour units, minute tens, minute units, second tens and second units.
- R10: seg = {a,b,c,d,e,f,g} (seg[6] is a) and is active high. The digits map as follows: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011. Tens digits are zero-extended to 4 bits before decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, one edge per second |
| scan_clk | input | 1 | Display multiplex clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_min_n | input | 1 | Active-low minute advance button |
| set_hour_n | input | 1 | Active-low hour advance button |
| buzzer | output | 1 | High during minute 00 |
| lamp | output | 3 | Chime lamp pattern |
| seg | output | 7 | Segments a..g, active high |
| digit_sel | output | 3 | Selected display position 0..5 |

## Verification
The bench runs a full day plus one minute from reset, one edge per second. After every edge it checks the displayed digit, the buzzer and the lamp phase against the elapsed-time arithmetic. This catches a counter that wraps at the wrong value and an hours stage that misses 23:59:59 to 00:00:00. It also catches a chime that starts one cycle late or leaks into minute 01.

The set tests cover three cases:
- Forcing the minutes across 59 while a seconds wrap lands on the same edge. A design that adds both steps ends one minute ahead. One that drops the minute carry leaves the hours stuck.
- Forcing the hours past 23. A design that fails here shows 24.
- A reset with a nonzero time. Any field left uncleared shows up on the display.

// File: rtl/bcd_chime_clock.sv
module bcd_chime_clock #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       scan_clk,
  input  logic       rst_n,
  input  logic       set_min_n,
  input  logic       set_hour_n,
  output logic       buzzer,
  output logic [2:0] lamp,
  output logic [6:0] seg,
  output logic [2:0] digit_sel
);

  logic [SYNC_STAGES-1:0] smin_sync, shr_sync;
  logic [3:0] sec_u, min_u, hr_u;
  logic [2:0] sec_t, min_t;
  logic [1:0] hr_t;
  logic [1:0] phase;
  logic [2:0] pos;
  logic [3:0] nib;
  logic set_min, set_hour, sec_last, min_last, hr_last;
  logic min_step, hr_step, hour_mark;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      smin_sync <= '1;
      shr_sync  <= '1;
    end else begin
      smin_sync <= {smin_sync[SYNC_STAGES-2:0], set_min_n};
      shr_sync  <= {shr_sync[SYNC_STAGES-2:0], set_hour_n};
    end

  assign set_min  = ~smin_sync[SYNC_STAGES-1];
  assign set_hour = ~shr_sync[SYNC_STAGES-1];

  assign sec_last = (sec_t == 3'd5) && (sec_u == 4'd9);
  assign min_last = (min_t == 3'd5) && (min_u == 4'd9);
  assign hr_last  = (hr_t == 2'd2) && (hr_u == 4'd3);
  assign min_step = sec_last | set_min;
  assign hr_step  = (min_step & min_last) | set_hour;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sec_u <= '0;
      sec_t <= '0;
    end else if (sec_u == 4'd9) begin
      sec_u <= '0;
      sec_t <= sec_last ? 3'd0 : sec_t + 3'd1;
    end else begin
      sec_u <= sec_u + 4'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      min_u <= '0;
      min_t <= '0;
    end else if (min_step) begin
      if (min_u == 4'd9) begin
        min_u <= '0;
        min_t <= min_last ? 3'd0 : min_t + 3'd1;
      end else begin
        min_u <= min_u + 4'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hr_u <= '0;
      hr_t <= '0;
    end else if (hr_step) begin
      if (hr_last) begin
        hr_u <= '0;
        hr_t <= '0;
      end else if (hr_u == 4'd9) begin
        hr_u <= '0;
        hr_t <= hr_t + 2'd1;
      end else begin
        hr_u <= hr_u + 4'd1;
      end
    end

  assign hour_mark = (min_t == 3'd0) && (min_u == 4'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase <= '0;
    else        phase <= hour_mark ? phase + 2'd1 : 2'd0;

  assign buzzer = hour_mark;

  always_comb begin
    lamp = 3'b000;
    if (hour_mark)
      case (phase)
        2'd1:    lamp = 3'b001;
        2'd2:    lamp = 3'b010;
        2'd3:    lamp = 3'b100;
        default: lamp = 3'b000;
      endcase
  end

  always_ff @(posedge scan_clk or negedge rst_n)
    if (!rst_n) pos <= '0;
    else        pos <= (pos == 3'd5) ? 3'd0 : pos + 3'd1;

  assign digit_sel = pos;

  always_comb
    case (pos)
      3'd0:    nib = {2'b00, hr_t};
      3'd1:    nib = hr_u;
      3'd2:    nib = {1'b0, min_t};
      3'd3:    nib = min_u;
      3'd4:    nib = {1'b0, sec_t};
      3'd5:    nib = sec_u;
      default: nib = 4'hf;
    endcase

  always_comb
    case (nib)
      4'd0:    seg = 7'b1111110;
      4'd1:    seg = 7'b0110000;
      4'd2:    seg = 7'b1101101;
      4'd3:    seg = 7'b1111001;
      4'd4:    seg = 7'b0110011;
      4'd5:    seg = 7'b1011011;
      4'd6:    seg = 7'b1011111;
      4'd7:    seg = 7'b1110000;
      4'd8:    seg = 7'b1111111;
      4'd9:    seg = 7'b1111011;
      default: seg = 7'b0000000;
    endcase

endmodule

// File: rtl/bcd_chime_clock_chk.sv
module bcd_chime_clock_chk (
  input logic       clk,
  input logic       scan_clk,
  input logic       rst_n,
  input logic [3:0] sec_u,
  input logic [2:0] sec_t,
  input logic [3:0] min_u,
  input logic [2:0] min_t,
  input logic [3:0] hr_u,
  input logic [1:0] hr_t,
  input logic       set_min,
  input logic       set_hour,
  input logic       buzzer,
  input logic [2:0] lamp,
  input logic [2:0] digit_sel
);

  p_sec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_u <= 4'd9) && (sec_t <= 3'd5));

  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_t == 3'd5 && sec_u == 4'd9) |=> (sec_t == 3'd0 && sec_u == 4'd0));

  p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sec_t == 3'd5 && sec_u == 4'd9) && !set_min) |=> $stable({min_t, min_u}));

  p_hour_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_t < 2'd2) || (hr_t == 2'd2 && hr_u <= 4'd3));

  p_hour_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(min_t == 3'd5 && min_u == 4'd9) && !set_hour) |=> $stable({hr_t, hr_u}));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ({min_t, min_u} != 7'd0) |-> (lamp == 3'b000 && !buzzer));

  p_lamp_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lamp));

  p_lamp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buzzer && lamp == 3'b001 && {min_t, min_u} == 7'd0 && !(sec_t == 3'd5 && sec_u == 4'd9) && !set_min)
      |=> lamp == 3'b010);

  p_sel_range_r9: assert property (@(posedge scan_clk) disable iff (!rst_n)
    digit_sel <= 3'd5);

  p_sel_wrap_r9: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (digit_sel == 3'd5) |=> (digit_sel == 3'd0));

endmodule

bind bcd_chime_clock bcd_chime_clock_chk chk_i (
  .clk(clk), .scan_clk(scan_clk), .rst_n(rst_n),
  .sec_u(sec_u), .sec_t(sec_t), .min_u(min_u), .min_t(min_t),
  .hr_u(hr_u), .hr_t(hr_t), .set_min(set_min), .set_hour(set_hour),
  .buzzer(buzzer), .lamp(lamp), .digit_sel(digit_sel)
);

// File: tb/bcd_chime_clock_tb_top.sv
`timescale 1ns/100ps
module bcd_chime_clock_tb_top;
  logic clk = 1'b0, scan_clk = 1'b0, rst_n = 1'b0;
  logic set_min_n = 1'b1, set_hour_n = 1'b1;
  logic buzzer;
  logic [2:0] lamp, digit_sel;
  logic [6:0] seg;
  bit clk_run = 1'b1;
  bit finished = 1'b0;
  int errs = 0, checks = 0;

  bcd_chime_clock dut_i (
    .clk(clk), .scan_clk(scan_clk), .rst_n(rst_n),
    .set_min_n(set_min_n), .set_hour_n(set_hour_n),
    .buzzer(buzzer), .lamp(lamp), .seg(seg), .digit_sel(digit_sel)
  );

  always begin
    #2;
    if (clk_run) clk = ~clk;
  end

  initial begin
    #0.5;
    forever #3 scan_clk = ~scan_clk;
  end

  function automatic logic [6:0] enc(int d);
    case (d)
      0: return 7'b1111110;  1: return 7'b0110000;
      2: return 7'b1101101;  3: return 7'b1111001;
      4: return 7'b0110011;  5: return 7'b1011011;
      6: return 7'b1011111;  7: return 7'b1110000;
      8: return 7'b1111111;  9: return 7'b1111011;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic int digit_at(int p, int h, int m, int s);
    case (p)
      0: return h / 10;  1: return h % 10;
      2: return m / 10;  3: return m % 10;
      4: return s / 10;  default: return s % 10;
    endcase
  endfunction

  function automatic logic [2:0] lamp_pat(int k);
    case (k % 4)
      0: return 3'b000;  1: return 3'b001;
      2: return 3'b010;  default: return 3'b100;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_all(int h, int m, int s, string req);
    int prev = -1;
    repeat (12) begin
      @(negedge scan_clk);
      #0.2;
      check(digit_sel <= 3'd5, "R9 digit_sel range", digit_sel, 5);
      check(seg == enc(digit_at(int'(digit_sel), h, m, s)), req, seg,
            enc(digit_at(int'(digit_sel), h, m, s)));
      if (prev >= 0)
        check(int'(digit_sel) == (prev + 1) % 6, "R9 digit order", digit_sel, (prev + 1) % 6);
      prev = int'(digit_sel);
    end
    check(buzzer == (m == 0), "R7 buzzer at set time", buzzer, m == 0);
  endtask

  initial begin
    #900000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int t;
    int h, m, s;
    #20;
    // R6 reset state
    check(digit_sel == 3'd0, "R6 digit_sel in reset", digit_sel, 0);
    check(seg == enc(0), "R6 display in reset", seg, enc(0));
    check(buzzer == 1'b1, "R7 buzzer at 00 in reset", buzzer, 1);
    check(lamp == 3'b000, "R8 lamp in reset", lamp, 0);

    // R1 R2 R3 R7 R8 R10: full-day sweep plus one minute
    @(negedge clk);
    rst_n = 1'b1;
    t = 0;
    for (int i = 0; i < 86460; i++) begin
      @(posedge clk);
      t++;
      @(negedge clk);
      h = (t / 3600) % 24;
      m = (t / 60) % 60;
      s = t % 60;
      check(seg == enc(digit_at(int'(digit_sel), h, m, s)), "R1/R2/R3 sweep digit", seg,
            enc(digit_at(int'(digit_sel), h, m, s)));
      check(buzzer == (m == 0), "R7 buzzer sweep", buzzer, m == 0);
      check(lamp == ((m == 0) ? lamp_pat(s) : 3'b000), "R8 lamp sweep", lamp,
            (m == 0) ? lamp_pat(s) : 3'b000);
    end

    // R4: fresh start, force minutes for 50 edges
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    set_min_n = 1'b0;
    repeat (50) @(negedge clk);
    set_min_n = 1'b1;
    repeat (2) @(negedge clk);
    clk_run = 1'b0;
    read_all(0, 50, 52, "R4 set minute 50 edges");
    clk_run = 1'b1;

    // R4 with R2 carry: force across 59 while seconds wrap coincides
    set_min_n = 1'b0;
    repeat (12) @(negedge clk);
    set_min_n = 1'b1;
    repeat (2) @(negedge clk);
    clk_run = 1'b0;
    read_all(1, 2, 6, "R4 forced minutes across wrap");
    clk_run = 1'b1;

    // R5 with R3: force hours past 23
    set_hour_n = 1'b0;
    repeat (23) @(negedge clk);
    set_hour_n = 1'b1;
    repeat (2) @(negedge clk);
    clk_run = 1'b0;
    read_all(0, 2, 31, "R5 set hour wraps");

    // R6: asynchronous reset with clock stopped
    rst_n = 1'b0;
    #5;
    check(digit_sel == 3'd0, "R6 selector cleared", digit_sel, 0);
    check(seg == enc(0), "R6 hour tens cleared", seg, enc(0));
    #0.3;
    rst_n = 1'b1;
    read_all(0, 0, 0, "R6 time cleared");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule